// File: doc/BRIEF.md
# Power Supervisor and Reset Sequencer

This block is the digital control for a supply supervisor that keeps SRAM contents alive on a backup cell. Analog comparators outside the block report whether the main supply sits above its trip point and whether it has fallen below the cell voltage. From these flags the block makes four decisions. It drives an open-drain reset that stays low while power is bad and for a hold time after power returns. It selects main or battery as the source for the memory supply rail. It records the memory organization strap at each power-up. It keeps a one-time shipping seal, so that a freshly attached cell is never drained before the system has been powered once.

`rst_n` clears the logic in the always-on (battery) domain, which happens when a cell is attached. Every duration is a count of `clk` cycles, set by a parameter. The defaults give a 200 ms hold and a 20 ms recovery strobe at 50 MHz. The strap arrives already decoded from its three pad states into two bits. All pins are plain level signals and carry no handshake.

Top module: `pwr_supervisor`

## Requirements
- R1: `rst_drive_low` is 1 in every cycle in which `vcc_ok` is 0.
- R2: After `vcc_ok` rises, `rst_drive_low` goes to 0 once `HOLD_CYC` consecutive rising clock edges have sampled `vcc_ok` high, and it stays 0 while `vcc_ok` stays high.
- R3: `src_battery` is 1 only when `vcc_ok` is 0, `vcc_lt_bat` is 1 and the seal is released. In every other case it is 0, which selects the main supply.
- R4: `org_mode` takes the decoded strap at the first rising edge that samples `vcc_ok` high after it was low. Strap changes at any other time have no effect.
- R5: Strap encoding: `strap` 2'b00 (tied low) gives `org_mode` 0 (four banks of one device). 2'b01 (tied high) gives 1 (two banks of two devices). 2'b10 or 2'b11 (open) gives 2 (one bank of four devices). After `rst_n`, `org_mode` is 0.
- R6: After `rst_n`, `seal_active` is 1 and `src_battery` is 0, whatever the other inputs are, until the first rising edge that samples `vcc_ok` high. That edge clears `seal_active`.
- R7: Once cleared, `seal_active` stays 0 through any later loss of supply. Only `rst_n` sets it again.
- R8: If `vcc_ok` drops during the hold time, the hold count restarts from zero at the next power-up.
- R9: `rec_done` is 1 for exactly one cycle. That cycle comes after `REC_CYC` consecutive edges have sampled `vcc_ok` high, provided `vcc_ok` is still high. `REC_CYC` must be smaller than `HOLD_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low clear of the always-on domain (cell attach) |
| vcc_ok | input | 1 | Main supply above trip point |
| vcc_lt_bat | input | 1 | Main supply below the cell voltage |
| strap | input | 2 | Decoded organization strap |
| rst_drive_low | output | 1 | Open-drain reset enable: 1 pulls the pin low |
| src_battery | output | 1 | 1 selects the cell, 0 selects the main supply |
| org_mode | output | 2 | Latched organization mode |
| seal_active | output | 1 | Shipping seal still engaged |
| rec_done | output | 1 | One-cycle strobe at the end of the recovery interval |

## Verification
`rst_drive_low`, `src_battery` and `rec_done` depend on `vcc_ok` and `vcc_lt_bat` with no delay. The bench therefore compares them in the same cycle in which the inputs change. The hold and recovery counts, the mode latch and the seal respond one edge after `vcc_ok` is sampled. A model in the bench advances only on rising edges and is compared with the design at every falling edge. Inputs change only just after that compare, so each result is checked in the exact cycle it becomes due, never early or late.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;
  typedef enum logic [1:0] {
    ORG_FOUR_X1 = 2'd0,
    ORG_TWO_X2  = 2'd1,
    ORG_ONE_X4  = 2'd2
  } org_t;

  function automatic org_t decode_strap(input logic [1:0] s);
    if (s[1])      return ORG_ONE_X4;
    else if (s[0]) return ORG_TWO_X2;
    else           return ORG_FOUR_X1;
  endfunction
endpackage

// File: rtl/por_timer.sv
module por_timer #(
  parameter int HOLD_CYC = 10_000_000,
  parameter int REC_CYC  = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  output logic rst_drive_low,
  output logic rec_done
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
  localparam logic [CW-1:0] REC_V  = CW'(REC_CYC);

  logic [CW-1:0] good_cnt;

  // counts consecutive edges with supply good, saturating at the hold limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             good_cnt <= '0;
    else if (!vcc_ok)       good_cnt <= '0;
    else if (good_cnt != HOLD_V) good_cnt <= good_cnt + 1'b1;
  end

  assign rst_drive_low = !vcc_ok || (good_cnt != HOLD_V);
  assign rec_done      = vcc_ok && (good_cnt == REC_V);
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import pwrsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ok,
  input  logic [1:0] strap,
  output logic [1:0] org_mode,
  output logic       seal_active
);
  logic vcc_seen;
  org_t org_q;
  logic seal_q;
  logic crossing;

  assign crossing = vcc_ok && !vcc_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_seen <= 1'b0;
      org_q    <= ORG_FOUR_X1;
      seal_q   <= 1'b1;
    end else begin
      vcc_seen <= vcc_ok;
      if (crossing) begin
        org_q  <= decode_strap(strap);
        seal_q <= 1'b0;
      end
    end
  end

  assign org_mode    = org_q;
  assign seal_active = seal_q;
endmodule

// File: rtl/src_select.sv
module src_select (
  input  logic vcc_ok,
  input  logic vcc_lt_bat,
  input  logic seal_active,
  output logic src_battery
);
  always_comb begin
    src_battery = 1'b0;
    if (!seal_active && !vcc_ok && vcc_lt_bat) src_battery = 1'b1;
  end
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int HOLD_CYC = 10_000_000,
  parameter int REC_CYC  = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ok,
  input  logic       vcc_lt_bat,
  input  logic [1:0] strap,
  output logic       rst_drive_low,
  output logic       src_battery,
  output logic [1:0] org_mode,
  output logic       seal_active,
  output logic       rec_done
);
  logic seal_w;

  por_timer #(.HOLD_CYC(HOLD_CYC), .REC_CYC(REC_CYC)) u_por (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok),
    .rst_drive_low(rst_drive_low), .rec_done(rec_done)
  );

  cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .strap(strap),
    .org_mode(org_mode), .seal_active(seal_w)
  );

  src_select u_src (
    .vcc_ok(vcc_ok), .vcc_lt_bat(vcc_lt_bat), .seal_active(seal_w),
    .src_battery(src_battery)
  );

  assign seal_active = seal_w;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_ok,
  input logic       vcc_lt_bat,
  input logic       rst_drive_low,
  input logic       src_battery,
  input logic [1:0] org_mode,
  input logic       seal_active,
  input logic       rec_done
);
  a_r1_reset_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |-> rst_drive_low);

  a_r2_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_drive_low) |-> (vcc_ok && $past(vcc_ok)));

  a_r3_battery_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    src_battery |-> (!vcc_ok && vcc_lt_bat));

  a_r4_mode_moves_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(org_mode) |-> $past(vcc_ok));

  a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    org_mode != 2'd3);

  a_r6_seal_blocks_battery: assert property (@(posedge clk) disable iff (!rst_n)
    seal_active |-> !src_battery);

  a_r7_seal_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    !seal_active |=> !seal_active);

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  a_r9_strobe_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> (vcc_ok && rst_drive_low));
endmodule

bind pwr_supervisor pwr_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_lt_bat(vcc_lt_bat),
  .rst_drive_low(rst_drive_low), .src_battery(src_battery),
  .org_mode(org_mode), .seal_active(seal_active), .rec_done(rec_done)
);

// File: tb/test_pwr_supervisor.sv
module test_pwr_supervisor;
  localparam int HOLD = 20;
  localparam int REC  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0;
  logic vcc_lt_bat = 1'b1;
  logic [1:0] strap = 2'b00;
  logic rst_drive_low, src_battery, seal_active, rec_done;
  logic [1:0] org_mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_supervisor #(.HOLD_CYC(HOLD), .REC_CYC(REC)) i_pwr_supervisor (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_lt_bat(vcc_lt_bat),
    .strap(strap), .rst_drive_low(rst_drive_low), .src_battery(src_battery),
    .org_mode(org_mode), .seal_active(seal_active), .rec_done(rec_done)
  );

  // behavioural reference: state advances on rising edges only
  int m_good = 0;
  bit m_prev = 0;
  bit m_seal = 1;
  int m_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_good = 0; m_prev = 0; m_seal = 1; m_mode = 0;
    end else begin
      if (vcc_ok) begin
        if (!m_prev) begin
          m_seal = 0;
          m_mode = strap[1] ? 2 : (strap[0] ? 1 : 0);
        end
        if (m_good < HOLD) m_good = m_good + 1;
      end else begin
        m_good = 0;
      end
      m_prev = vcc_ok;
    end
  end

  task automatic check1(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int e_rst, e_src, e_rec;
    e_rst = (!vcc_ok || m_good < HOLD) ? 1 : 0;          // R1 R2 R8
    e_src = (!vcc_ok && vcc_lt_bat && !m_seal) ? 1 : 0;  // R3 R6
    e_rec = (vcc_ok && m_good == REC) ? 1 : 0;           // R9
    check1("R1/R2/R8 rst_drive_low", int'(rst_drive_low), e_rst);
    check1("R3/R6 src_battery", int'(src_battery), e_src);
    check1("R4/R5 org_mode", int'(org_mode), m_mode);
    check1("R6/R7 seal_active", int'(seal_active), int'(m_seal));
    check1("R9 rec_done", int'(rec_done), e_rec);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R6: sealed, supply low and below cell, battery must not be chosen
    tick(5);
    // R5 tied high; R8: drop during hold
    strap = 2'b01; vcc_ok = 1'b1;
    tick(8);
    vcc_ok = 1'b0;
    // R3 battery now allowed; R7 seal stays released
    tick(4);
    vcc_lt_bat = 1'b0;
    tick(2);
    vcc_lt_bat = 1'b1;
    // R4: strap open at crossing, changed during hold (ignored)
    strap = 2'b10;
    tick(2);
    vcc_ok = 1'b1;
    tick(3);
    strap = 2'b00;
    tick(HOLD + 5);            // R2 release, R9 strobe
    vcc_lt_bat = 1'b1;
    tick(3);                   // R3: supply good, no battery
    // R5 open as 2'b11, R4 re-latch on next power-up
    vcc_ok = 1'b0;
    strap = 2'b11;
    tick(3);
    vcc_ok = 1'b1;
    tick(HOLD + 2);
    // R5 tied low
    vcc_ok = 1'b0;
    strap = 2'b00;
    tick(2);
    vcc_ok = 1'b1;
    tick(REC + 2);
    vcc_ok = 1'b0;             // R9 no strobe when interrupted before REC
    tick(2);
    vcc_ok = 1'b1;
    tick(REC - 2);
    vcc_ok = 1'b0;
    tick(3);
    // R6: new cell attach re-seals
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule